// File: doc/BRIEF.md
# Register-Driven Reconfiguration Port Bridge

This block sits between a 32-bit memory-mapped register bus and the dynamic reconfiguration port (DRP) of a clock generator. Software writes one packed command word. The word holds a start flag, a direction flag, a port address and 16 bits of write data. The bridge then runs a single handshake on the port. While that transaction is open it shows a busy flag. When a read completes, it keeps the returned data in a status word.

A separate two-bit register drives two lines. One releases the surrounding core from reset. The other lets the clock generator run. These lines are needed because the generator must be held while its settings are rewritten.

Changing only some bits of a port register takes four steps: wait for idle, launch a read, wait for idle, then write the merged value to the same address. The bus side is a small subset of AXI4-Lite. It uses single-beat, full-word accesses and has no response codes.

Top module: `drp_bridge`

## Requirements
- R1: After reset, `drpEn`, `drpWe`, `coreRstN`, `genRun`, `bValid` and `rValid` are low, and the status word reads zero.
- R2: A write to byte offset 0x40 loads the run register on the accepting edge. Bit 0 drives `coreRstN`, and bit 1 drives `genRun` (0 holds the generator). A read of 0x40 returns these two bits, with all other bits zero.
- R3: A write to offset 0x70 with bit 29 set, accepted while idle, raises `drpEn` for exactly the one cycle after the accepting edge. In that cycle `drpAddr` equals bits 22:16 and `drpDi` equals bits 15:0 of the word.
- R4: Bit 28 of the command word picks the direction. When it is set, the transaction is a read and `drpWe` stays low. When it is clear, the transaction is a write and `drpWe` is high together with `drpEn`.
- R5: Status bit 16 (offset 0x74) is set from the edge that accepts a launching command. A status read issued right after the command therefore sees it. The bit stays set until `drpRdy` is sampled high, and it is clear from the next cycle.
- R6: Status bits 15:0 are loaded from `drpDo` only on the `drpRdy` cycle of a read. The completion of a write leaves them unchanged.
- R7: A command write accepted while busy is dropped. No `drpEn` pulse follows it. `drpAddr` and `drpDi` keep the values of the transaction in flight, and that transaction still completes normally.
- R8: A write to 0x70 with bit 29 clear starts nothing, and busy stays clear.
- R9: Offset 0x70 reads as zero, and so does every unmapped offset. Writes to unmapped offsets change no output.
- R10: A write is accepted when `awValid` and `wValid` are both high and no response is pending. `bValid` then holds until `bReady`. A read is accepted when `arValid` is high and no read data is pending. `rValid` and `rData` then hold until `rReady`.
- R11: A read of a port register, followed by a write of a modified value to the same address, leaves the modified value in the port register, as a later read shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address accepted |
| awAddr | input | 8 | Write byte address |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data accepted |
| wData | input | 32 | Write data |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response taken |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address accepted |
| arAddr | input | 8 | Read byte address |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data taken |
| rData | output | 32 | Read data |
| drpEn | output | 1 | Port transaction strobe |
| drpWe | output | 1 | Port write strobe |
| drpAddr | output | 7 | Port register address |
| drpDi | output | 16 | Port write data |
| drpDo | input | 16 | Port read data |
| drpRdy | input | 1 | Port transaction complete |
| coreRstN | output | 1 | Core reset release (high = run) |
| genRun | output | 1 | Clock generator run enable |

## Verification
The assertions assume that the port raises `drpRdy` only for an open transaction, and never in the same cycle as `drpEn`. They also assume that bus masters keep their valid signals up until the transfer is accepted. The bench port model answers each strobe once, after a latency of one to four cycles, or after a fixed long latency when a test needs a wide busy window. The bus tasks hold valid until the ready is seen. Random commands cover mixed reads and writes at random addresses, with random data, and are compared with a bench-side register image. Directed cases cover commands dropped while busy, commands without the start flag, stalled responses and read-modify-write.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;

  // command word layout (decoded by the port side, so positions are fixed)
  localparam int CMD_GO_BIT    = 29;
  localparam int CMD_RD_BIT    = 28;
  localparam int CMD_ADDR_LSB  = 16;
  localparam int STAT_BUSY_BIT = 16;

  // byte offsets of the mapped words
  localparam logic [7:0] OFF_RUN  = 8'h40;
  localparam logic [7:0] OFF_CMD  = 8'h70;
  localparam logic [7:0] OFF_STAT = 8'h74;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_RUN  = 2'd1,
    SEL_STAT = 2'd2
  } rdSel_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } cmdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   launch;
    logic   done;
    logic   runWr;
    logic   rdLoad;
    rdSel_t rdSel;
  } ctrlStb_t;

endpackage

// File: rtl/drp_bridge_ctrl.sv
module drp_bridge_ctrl
  import drp_bridge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              awValid,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              wValid,
  input  logic              cmdGo,
  output logic              wrAccept,
  output logic              bValid,
  input  logic              bReady,
  input  logic              arValid,
  input  logic [ADDR_W-1:0] arAddr,
  output logic              rdAccept,
  output logic              rValid,
  input  logic              rReady,
  input  logic              drpRdy,
  output logic              busy,
  output ctrlStb_t          stb
);

  cmdState_t state;

  function automatic logic hitOff(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return (a >> 2) == (ADDR_W'(off) >> 2);
  endfunction

  assign wrAccept = awValid && wValid && !bValid;
  assign rdAccept = arValid && !rValid;
  assign busy     = (state == ST_WAIT);

  always_comb begin
    stb        = '0;
    stb.launch = wrAccept && hitOff(awAddr, OFF_CMD) && cmdGo && (state == ST_IDLE);
    stb.done   = (state == ST_WAIT) && drpRdy;
    stb.runWr  = wrAccept && hitOff(awAddr, OFF_RUN);
    stb.rdLoad = rdAccept;
    if (hitOff(arAddr, OFF_RUN))       stb.rdSel = SEL_RUN;
    else if (hitOff(arAddr, OFF_STAT)) stb.rdSel = SEL_STAT;
    else                               stb.rdSel = SEL_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (stb.launch) state <= ST_WAIT;
        ST_WAIT: if (drpRdy)     state <= ST_IDLE;
        default:                 state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bValid <= 1'b0;
      rValid <= 1'b0;
    end else begin
      if (wrAccept)    bValid <= 1'b1;
      else if (bReady) bValid <= 1'b0;
      if (rdAccept)    rValid <= 1'b1;
      else if (rReady) rValid <= 1'b0;
    end
  end

  // R5: busy is set on the edge that accepts a launch
  a_r5_busy_after_launch: assert property (@(posedge clk) disable iff (!rstN)
    stb.launch |=> busy);
  // R5: busy holds until the port answers
  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !drpRdy) |=> busy);
  // R10: responses stay up until taken
  a_r10_bvalid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> bValid);
  a_r10_rvalid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> rValid);

endmodule

// File: rtl/drp_bridge_dp.sv
module drp_bridge_dp
  import drp_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DRP_AW = 7,
  parameter int DRP_DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              busy,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData,
  output logic              drpEn,
  output logic              drpWe,
  output logic [DRP_AW-1:0] drpAddr,
  output logic [DRP_DW-1:0] drpDi,
  input  logic [DRP_DW-1:0] drpDo,
  output logic              coreRstN,
  output logic              genRun
);

  localparam int RUN_W = 2;

  logic [RUN_W-1:0]  runReg;
  logic              pendRead;
  logic [DRP_DW-1:0] rdHold;
  logic [DATA_W-1:0] rdWord;
  logic              unusedWData;

  assign unusedWData = ^wData;
  assign coreRstN    = runReg[0];
  assign genRun      = runReg[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReg <= '0;
    end else if (stb.runWr) begin
      runReg <= wData[RUN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      drpEn    <= 1'b0;
      drpWe    <= 1'b0;
      drpAddr  <= '0;
      drpDi    <= '0;
      pendRead <= 1'b0;
    end else begin
      drpEn <= stb.launch;
      drpWe <= stb.launch && !wData[CMD_RD_BIT];
      if (stb.launch) begin
        drpAddr  <= wData[CMD_ADDR_LSB +: DRP_AW];
        drpDi    <= wData[DRP_DW-1:0];
        pendRead <= wData[CMD_RD_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdHold <= '0;
    end else if (stb.done && pendRead) begin
      rdHold <= drpDo;
    end
  end

  always_comb begin
    rdWord = '0;
    case (stb.rdSel)
      SEL_RUN:  rdWord[RUN_W-1:0] = runReg;
      SEL_STAT: begin
        rdWord[DRP_DW-1:0]    = rdHold;
        rdWord[STAT_BUSY_BIT] = busy;
      end
      default:  rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rData <= '0;
    end else if (stb.rdLoad) begin
      rData <= rdWord;
    end
  end

  // R3: the port strobe lasts a single cycle
  a_r3_en_pulse: assert property (@(posedge clk) disable iff (!rstN)
    drpEn |=> !drpEn);
  // R4: write strobe only together with the transaction strobe
  a_r4_we_with_en: assert property (@(posedge clk) disable iff (!rstN)
    drpWe |-> drpEn);
  // R7: the command in flight is not disturbed
  a_r7_cmd_stable: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || ($stable(drpAddr) && $stable(drpDi))));
  // R6: held read data only changes on a completion
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stb.done |=> $stable(rdHold));

endmodule

// File: rtl/drp_bridge.sv
module drp_bridge
  import drp_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DRP_AW = 7,
  parameter int DRP_DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              awValid,
  output logic              awReady,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              wValid,
  output logic              wReady,
  input  logic [DATA_W-1:0] wData,
  output logic              bValid,
  input  logic              bReady,
  input  logic              arValid,
  output logic              arReady,
  input  logic [ADDR_W-1:0] arAddr,
  output logic              rValid,
  input  logic              rReady,
  output logic [DATA_W-1:0] rData,
  output logic              drpEn,
  output logic              drpWe,
  output logic [DRP_AW-1:0] drpAddr,
  output logic [DRP_DW-1:0] drpDi,
  input  logic [DRP_DW-1:0] drpDo,
  input  logic              drpRdy,
  output logic              coreRstN,
  output logic              genRun
);

  ctrlStb_t stb;
  logic     wrAccept;
  logic     rdAccept;
  logic     busy;

  assign awReady = wrAccept;
  assign wReady  = wrAccept;
  assign arReady = rdAccept;

  drp_bridge_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .awValid  (awValid),
    .awAddr   (awAddr),
    .wValid   (wValid),
    .cmdGo    (wData[CMD_GO_BIT]),
    .wrAccept (wrAccept),
    .bValid   (bValid),
    .bReady   (bReady),
    .arValid  (arValid),
    .arAddr   (arAddr),
    .rdAccept (rdAccept),
    .rValid   (rValid),
    .rReady   (rReady),
    .drpRdy   (drpRdy),
    .busy     (busy),
    .stb      (stb)
  );

  drp_bridge_dp #(.DATA_W(DATA_W), .DRP_AW(DRP_AW), .DRP_DW(DRP_DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busy     (busy),
    .wData    (wData),
    .rData    (rData),
    .drpEn    (drpEn),
    .drpWe    (drpWe),
    .drpAddr  (drpAddr),
    .drpDi    (drpDi),
    .drpDo    (drpDo),
    .coreRstN (coreRstN),
    .genRun   (genRun)
  );

endmodule

// File: tb/drp_bridge_tb.sv
`timescale 1ns/1ps
module drp_bridge_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        awValid = 1'b0, wValid = 1'b0, bReady = 1'b1;
  logic        arValid = 1'b0, rReady = 1'b1;
  logic [7:0]  awAddr = '0, arAddr = '0;
  logic [31:0] wData = '0;
  logic        awReady, wReady, bValid, arReady, rValid;
  logic [31:0] rData;
  logic        drpEn, drpWe, coreRstN, genRun;
  logic [6:0]  drpAddr;
  logic [15:0] drpDi;
  logic [15:0] drpDo = '0;
  logic        drpRdy = 1'b0;

  int total = 0;
  int bad = 0;
  int forcedLat = 0;
  logic [15:0] refMem [128];

  always #4 clk = ~clk;

  drp_bridge u_dut (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
    .wValid(wValid), .wReady(wReady), .wData(wData),
    .bValid(bValid), .bReady(bReady),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr),
    .rValid(rValid), .rReady(rReady), .rData(rData),
    .drpEn(drpEn), .drpWe(drpWe), .drpAddr(drpAddr), .drpDi(drpDi),
    .drpDo(drpDo), .drpRdy(drpRdy),
    .coreRstN(coreRstN), .genRun(genRun)
  );

  function automatic logic [15:0] initVal(input int i);
    return 16'(i * 37 + 16'h0100);
  endfunction

  function automatic logic [31:0] cmdWord(input logic go, input logic rd,
                                          input logic [6:0] a, input logic [15:0] d);
    return {2'b00, go, rd, 5'b0, a, d};
  endfunction

  // port model: answers each strobe once after a latency
  logic [15:0] genMem [128];
  logic        pend = 1'b0;
  int          lat = 0;
  logic [6:0]  pAddr;
  logic        pWe;
  logic [15:0] pDi;
  always @(posedge clk) begin
    drpRdy <= 1'b0;
    drpDo  <= 16'hDEAD;
    if (!rstN) begin
      pend <= 1'b0;
      for (int i = 0; i < 128; i++) genMem[i] <= initVal(i);
    end else if (drpEn) begin
      pend  <= 1'b1;
      lat   <= (forcedLat != 0) ? forcedLat : 1 + int'($urandom % 4);
      pAddr <= drpAddr;
      pWe   <= drpWe;
      pDi   <= drpDi;
    end else if (pend) begin
      if (lat <= 1) begin
        pend   <= 1'b0;
        drpRdy <= 1'b1;
        drpDo  <= genMem[pAddr];
        if (pWe) genMem[pAddr] <= pDi;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    awValid = 1'b1; wValid = 1'b1; awAddr = a; wData = d;
    #1;
    while (!awReady) begin @(negedge clk); #1; end
    @(negedge clk);
    awValid = 1'b0; wValid = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    arValid = 1'b1; arAddr = a;
    #1;
    while (!arReady) begin @(negedge clk); #1; end
    @(negedge clk);
    arValid = 1'b0;
    d = rData;
  endtask

  task automatic waitIdle(output logic [31:0] st);
    st = 32'h0001_0000;
    for (int n = 0; n < 200 && st[16]; n++) busRead(8'h74, st);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, st;
    logic [6:0]  a;
    logic [15:0] d;
    logic        rd;
    void'($urandom(32'd12345));
    for (int i = 0; i < 128; i++) refMem[i] = initVal(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 drpEn", drpEn, 0);
    chk("R1 drpWe", drpWe, 0);
    chk("R1 coreRstN", coreRstN, 0);
    chk("R1 genRun", genRun, 0);
    chk("R1 bValid", bValid, 0);
    chk("R1 rValid", rValid, 0);
    busRead(8'h74, v);
    chk("R1 status", v, 0);

    // R2: run register
    busWrite(8'h40, 32'hFFFF_FFF1);
    chk("R2 coreRstN", coreRstN, 1);
    chk("R2 genRun held", genRun, 0);
    busRead(8'h40, v);
    chk("R2 readback", v, 32'h1);
    busWrite(8'h40, 32'h3);
    chk("R2 genRun", genRun, 1);
    busRead(8'h40, v);
    chk("R2 readback3", v, 32'h3);

    // R9: zero reads and unmapped writes
    busRead(8'h10, v);
    chk("R9 unmapped read", v, 0);
    busWrite(8'h44, 32'h3000_0000);
    chk("R9 unmapped no strobe", drpEn, 0);
    busRead(8'h40, v);
    chk("R9 run unchanged", v, 32'h3);

    // R3 R4 R5: directed write command
    busWrite(8'h70, cmdWord(1, 0, 7'h55, 16'hA5C3));
    refMem[7'h55] = 16'hA5C3;
    chk("R3 en", drpEn, 1);
    chk("R3 addr", drpAddr, 7'h55);
    chk("R3 data", drpDi, 16'hA5C3);
    chk("R4 we on write", drpWe, 1);
    busRead(8'h74, v);
    chk("R5 busy immediate", v[16], 1);
    chk("R3 en one cycle", drpEn, 0);
    busRead(8'h70, v);
    chk("R9 cmd reads zero", v, 0);
    waitIdle(st);
    chk("R6 write leaves data", st, 0);

    // R4 R6: directed read command
    busWrite(8'h70, cmdWord(1, 1, 7'h55, 16'h0000));
    chk("R4 we low on read", drpWe, 0);
    chk("R4 en on read", drpEn, 1);
    waitIdle(st);
    chk("R6 read data", st, {16'h0, refMem[7'h55]});

    // R8: no start flag
    busWrite(8'h70, cmdWord(0, 0, 7'h11, 16'h1234));
    chk("R8 no strobe", drpEn, 0);
    busRead(8'h74, v);
    chk("R8 not busy", v[16], 0);

    // R7: command while busy is dropped
    forcedLat = 20;
    busWrite(8'h70, cmdWord(1, 0, 7'h05, 16'h1111));
    refMem[7'h05] = 16'h1111;
    busWrite(8'h70, cmdWord(1, 0, 7'h09, 16'h2222));
    chk("R7 no strobe", drpEn, 0);
    chk("R7 addr kept", drpAddr, 7'h05);
    chk("R7 data kept", drpDi, 16'h1111);
    waitIdle(st);
    chk("R7 busy cleared", st[16], 0);
    forcedLat = 0;
    busWrite(8'h70, cmdWord(1, 1, 7'h09, 16'h0));
    waitIdle(st);
    chk("R7 dropped write absent", st[15:0], refMem[7'h09]);
    busWrite(8'h70, cmdWord(1, 1, 7'h05, 16'h0));
    waitIdle(st);
    chk("R7 first write done", st[15:0], 16'h1111);

    // R11: read-modify-write of bits 7:4
    busWrite(8'h70, cmdWord(1, 1, 7'h30, 16'h0));
    waitIdle(st);
    d = (st[15:0] & ~16'h00F0) | 16'h00A0;
    busWrite(8'h70, cmdWord(1, 0, 7'h30, d));
    refMem[7'h30] = d;
    waitIdle(st);
    busWrite(8'h70, cmdWord(1, 1, 7'h30, 16'h0));
    waitIdle(st);
    chk("R11 rmw", st[15:0], (initVal(7'h30) & ~16'h00F0) | 16'h00A0);

    // R10: stalled responses
    bReady = 1'b0;
    busWrite(8'h40, 32'h1);
    @(negedge clk); @(negedge clk);
    chk("R10 bValid held", bValid, 1);
    bReady = 1'b1;
    @(negedge clk);
    chk("R10 bValid dropped", bValid, 0);
    rReady = 1'b0;
    busRead(8'h40, v);
    @(negedge clk); @(negedge clk);
    chk("R10 rValid held", rValid, 1);
    chk("R10 rData held", rData, 32'h1);
    rReady = 1'b1;
    @(negedge clk);
    chk("R10 rValid dropped", rValid, 0);

    // R3 R4 R6: random commands against the register image
    for (int k = 0; k < 60; k++) begin
      rd = 1'($urandom % 2);
      a  = 7'($urandom);
      d  = 16'($urandom);
      busWrite(8'h70, cmdWord(1, rd, a, d));
      chk("R3 random addr", drpAddr, a);
      chk("R4 random dir", drpWe, !rd);
      if (!rd) refMem[a] = d;
      waitIdle(st);
      if (rd) chk("R6 random read", st[15:0], refMem[a]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule